// File: doc/BRIEF.md
# Dual-Policy Cache Cost Meter

This block models a small fully associative cache purely for its cost, not its contents. A single stream of read and write requests, each naming one block address, drives two shadow copies of the cache at once: one runs a write-through policy, the other a write-back policy. Each copy has its own tag store, valid bits, recency ranks and dirty bits. Each copy keeps a running latency total and a count of writes that would reach memory.

The fill cost and the store cost arrive with every request, so that one stream can be priced under several memory models. The write-back copy also reports, at all times, how many of its resident lines hold data that has not yet gone to memory. This is a measure of exposure to power loss. Nothing is ever flushed, so the block can be used to compare the traffic and latency of the two policies over any trace.

Top module: `dual_policy_cache_meter`

## Requirements
- R1: Both copies are fully associative. A read and a write each make the accessed line the most recently used. A miss fills the lowest-numbered invalid way if one exists, and otherwise replaces the least recently used line. A write miss allocates the line exactly as a read miss does.
- R2: Every accepted request adds 1 to the latency total of each copy. A miss adds the fill cost on top of that.
- R3: In the write-through copy, every write request, hit or miss, adds the store cost to the latency and increments the write count by one. Lines in this copy are never dirty.
- R4: In the write-back copy, a write sets the line's dirty flag and adds no memory write and no store cost by itself.
- R5: In the write-back copy, replacing a dirty line adds the store cost and one memory write. Replacing a clean line adds nothing beyond the miss cost.
- R6: `wb_dirty_lines` always equals the number of valid dirty lines in the write-back copy. No flush ever happens. On a write-back miss, the new line is dirty only when the request is a write.
- R7: A request is taken on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is high whenever reset is low. `req_write` encodes 0 for a read and 1 for a write. With `req_valid` low, no counter or line state changes.
- R8: A synchronous active-high reset clears all counters, valid bits and dirty bits, and restores a fixed recency order.
- R9: All counters reflect a request from the clock edge that accepts it onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 0 = read, 1 = write |
| req_addr | input | AW | Block address |
| cost_fill | input | CW | Latency charged for a miss fetch |
| cost_store | input | CW | Latency charged for each memory write |
| wt_latency | output | LW | Write-through latency total |
| wt_writes | output | NW | Write-through memory write count |
| wb_latency | output | LW | Write-back latency total |
| wb_writes | output | NW | Write-back memory write count |
| wb_dirty_lines | output | $clog2(WAYS+1) | Valid dirty lines in the write-back copy |

## Verification
Every result is registered once, on the edge that accepts the request, so each counter and the dirty-line count are due one edge after the request is presented. The bench drives requests on falling edges and holds each for exactly one cycle. It reads the outputs on the falling edge after the last request of a scenario, when all accepted requests have landed and no new one is pending. Idle cycles with changing address, operation and costs are inserted before a read-back to show that nothing moves without a handshake.

// File: rtl/dual_policy_cache_meter.sv
module dual_policy_cache_meter #(
  parameter int WAYS = 4,
  parameter int AW   = 16,
  parameter int CW   = 32,
  parameter int LW   = 64,
  parameter int NW   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [AW-1:0]              req_addr,
  input  logic [CW-1:0]              cost_fill,
  input  logic [CW-1:0]              cost_store,
  output logic [LW-1:0]              wt_latency,
  output logic [NW-1:0]              wt_writes,
  output logic [LW-1:0]              wb_latency,
  output logic [NW-1:0]              wb_writes,
  output logic [$clog2(WAYS+1)-1:0]  wb_dirty_lines
);
  localparam int RW = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int DW = $clog2(WAYS+1);
  localparam logic [RW-1:0] OLDEST = RW'(WAYS-1);

  logic accept;
  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;

  logic [LW-1:0] lat_all [2];
  logic [NW-1:0] wr_all  [2];
  logic          hit_all [2];
  logic [DW-1:0] dcnt_all[2];

  for (genvar p = 0; p < 2; p++) begin : g_copy
    logic [AW-1:0] tag_q  [WAYS];
    logic [RW-1:0] rank_q [WAYS];
    logic [WAYS-1:0] vld_q, drt_q;
    logic [LW-1:0] lat_q;
    logic [NW-1:0] wr_q;
    logic          hit, free_found, evict_dirty, mem_wr;
    logic [RW-1:0] hit_idx, free_idx, lru_idx, sel;
    logic [DW-1:0] dcnt;
    logic [LW-1:0] add;

    always_comb begin
      hit = 1'b0; hit_idx = '0;
      free_found = 1'b0; free_idx = '0;
      lru_idx = '0; dcnt = '0;
      for (int i = 0; i < WAYS; i++) begin
        if (vld_q[i] && tag_q[i] == req_addr) begin
          hit = 1'b1; hit_idx = RW'(i);
        end
        if (rank_q[i] == OLDEST) lru_idx = RW'(i);
        if (vld_q[i] && drt_q[i]) dcnt = dcnt + 1'b1;
      end
      for (int i = WAYS-1; i >= 0; i--) begin
        if (!vld_q[i]) begin
          free_found = 1'b1; free_idx = RW'(i);
        end
      end
    end

    assign sel         = hit ? hit_idx : (free_found ? free_idx : lru_idx);
    assign evict_dirty = !hit && !free_found && vld_q[lru_idx] && drt_q[lru_idx];
    assign mem_wr      = (p == 0) ? req_write : evict_dirty;
    assign add = LW'(1)
               + (hit    ? '0 : LW'(cost_fill))
               + (mem_wr ? LW'(cost_store) : '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
        drt_q <= '0;
        lat_q <= '0;
        wr_q  <= '0;
        for (int i = 0; i < WAYS; i++) begin
          rank_q[i] <= RW'(i);
          tag_q[i]  <= '0;
        end
      end else if (accept) begin
        lat_q <= lat_q + add;
        if (mem_wr) wr_q <= wr_q + 1'b1;
        tag_q[sel] <= req_addr;
        vld_q[sel] <= 1'b1;
        if (p == 1) drt_q[sel] <= hit ? (drt_q[sel] | req_write) : req_write;
        for (int i = 0; i < WAYS; i++) begin
          if (RW'(i) == sel)              rank_q[i] <= '0;
          else if (rank_q[i] < rank_q[sel]) rank_q[i] <= rank_q[i] + 1'b1;
        end
      end
    end

    assign lat_all[p]  = lat_q;
    assign wr_all[p]   = wr_q;
    assign hit_all[p]  = hit;
    assign dcnt_all[p] = dcnt;
  end

  assign wt_latency     = lat_all[0];
  assign wt_writes      = wr_all[0];
  assign wb_latency     = lat_all[1];
  assign wb_writes      = wr_all[1];
  assign wb_dirty_lines = dcnt_all[1];

  a_r1_copies_agree: assert property (@(posedge clk) disable iff (rst)
    accept |-> hit_all[0] == hit_all[1]);
  a_r2_latency_grows: assert property (@(posedge clk) disable iff (rst)
    accept |=> wt_latency > $past(wt_latency) && wb_latency > $past(wb_latency));
  a_r3_wt_write_counted: assert property (@(posedge clk) disable iff (rst)
    accept && req_write |=> wt_writes == $past(wt_writes) + 1'b1);
  a_r3_wt_clean: assert property (@(posedge clk) disable iff (rst)
    dcnt_all[0] == '0);
  a_r4_wb_write_hit_silent: assert property (@(posedge clk) disable iff (rst)
    accept && hit_all[1] |=> wb_writes == $past(wb_writes));
  a_r6_read_hit_keeps_dirty: assert property (@(posedge clk) disable iff (rst)
    accept && !req_write && hit_all[1] |=> $stable(wb_dirty_lines));
  a_r6_dirty_bound: assert property (@(posedge clk) disable iff (rst)
    wb_dirty_lines <= DW'(WAYS));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(wt_latency) && $stable(wb_latency) && $stable(wt_writes)
                   && $stable(wb_writes) && $stable(wb_dirty_lines));
endmodule

// File: tb/tb_dual_policy_cache_meter.sv
module tb_dual_policy_cache_meter;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] cost_fill = '0, cost_store = '0;
  logic req_ready;
  logic [63:0] wt_latency, wb_latency;
  logic [31:0] wt_writes, wb_writes;
  logic [1:0]  wb_dirty_lines;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dual_policy_cache_meter #(.WAYS(2)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .cost_fill(cost_fill),
    .cost_store(cost_store), .wt_latency(wt_latency), .wt_writes(wt_writes),
    .wb_latency(wb_latency), .wb_writes(wb_writes), .wb_dirty_lines(wb_dirty_lines));

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; req_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic send(bit wr, int addr, int rc, int wc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 16'(addr);
    cost_fill = 32'(rc); cost_store = 32'(wc);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_all(string tag, int wtl, int wtw, int wbl, int wbw, int dl);
    chk({tag, " wt_latency"}, wt_latency, 64'(wtl));
    chk({tag, " wt_writes"},  64'(wt_writes), 64'(wtw));
    chk({tag, " wb_latency"}, wb_latency, 64'(wbl));
    chk({tag, " wb_writes"},  64'(wb_writes), 64'(wbw));
    chk({tag, " wb_dirty_lines"}, 64'(wb_dirty_lines), 64'(dl));
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    chk("R7 ready after reset", 64'(req_ready), 64'd1);
    expect_all("R8 reset", 0, 0, 0, 0, 0);
  endtask

  task automatic t_same_block_twice();
    do_reset();
    send(1, 1, 5, 10); send(1, 1, 5, 10);
    expect_all("R3 R4 W1 W1", 27, 2, 7, 0, 1);
  endtask

  task automatic t_dirty_eviction();
    do_reset();
    send(1, 1, 5, 10); send(0, 2, 5, 10); send(1, 3, 5, 10);
    expect_all("R5 dirty evict", 38, 2, 28, 1, 1);
  endtask

  task automatic t_lru_order();
    do_reset();
    send(0, 1, 4, 7); send(1, 2, 4, 7); send(0, 1, 4, 7);
    send(1, 3, 4, 7); send(0, 2, 4, 7);
    expect_all("R1 LRU refresh", 35, 2, 28, 1, 1);
  endtask

  task automatic t_clean_eviction();
    do_reset();
    send(0, 1, 3, 9); send(0, 2, 3, 9); send(0, 3, 3, 9);
    expect_all("R5 clean evict", 12, 0, 12, 0, 0);
  endtask

  task automatic t_dirty_count_and_idle();
    do_reset();
    send(1, 1, 1, 1); send(1, 2, 1, 1);
    expect_all("R6 two dirty", 6, 2, 4, 0, 2);
    send(0, 1, 1, 1);
    expect_all("R2 R6 read hit", 7, 2, 5, 0, 2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      req_write = k[0]; req_addr = 16'(k + 7); cost_fill = 99; cost_store = 77;
    end
    @(negedge clk);
    expect_all("R7 idle no change", 7, 2, 5, 0, 2);
  endtask

  task automatic t_write_miss_alloc();
    do_reset();
    send(1, 4, 2, 3); send(0, 4, 2, 3);
    expect_all("R1 R9 write alloc then hit", 7, 1, 4, 0, 1);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_same_block_twice();
        t_dirty_eviction();
        t_lru_order();
        t_clean_eviction();
        t_dirty_count_and_idle();
        t_write_miss_alloc();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule